// File: doc/BRIEF.md
# Boundary-Aware Flash Transfer Chunk Splitter

This block accepts one large flash transfer request (start offset, byte count, direction) and cuts it into a series of bounded sub-transfers. Each sub-transfer goes out on a downstream valid/ready port as an offset, a length and a direction bit. The block waits for that sub-transfer to be acknowledged before it works out and issues the next one. When the final piece is acknowledged, the block pulses a completion strobe and reports the total number of bytes moved.

The largest piece is one page of 4096 bytes. The page size is a power-of-two parameter. Reads are cut into full pages, with a shorter tail, no matter how the start offset is aligned. Writes are cut so that no piece straddles a page boundary. An unaligned write therefore begins with a short piece that runs up to the next boundary. The downstream data mover and the flash command sequencing are outside this block.

Top module: `xfer_chunker`

## Requirements
- R1: For a read (direction bit 0), every piece length equals the smaller of 4096 and the bytes still outstanding, whatever the alignment of the offset.
- R2: For a write (direction bit 1) whose current offset is not a multiple of 4096, the piece length equals the smaller of the outstanding bytes and 4096 minus (offset mod 4096), so no write piece crosses a 4096-byte boundary.
- R3: For a write at a 4096-aligned offset, the piece length equals the smaller of 4096 and the outstanding bytes.
- R4: The first piece starts at the requested offset. Each later piece starts at the previous offset plus the previous length. Every piece carries the request's direction bit (0 read, 1 write), and the lengths add up to the requested count.
- R5: At most one piece is outstanding at a time. While `chk_valid` is high and `chk_ready` is low, the offset, length and direction stay stable. After an acknowledge, `chk_valid` is low for at least one cycle before the next piece.
- R6: In the cycle after the final piece is acknowledged, `done` is high for one cycle, `done_bytes` equals the requested length, and `busy` and `chk_valid` are low.
- R7: A request of length zero issues no piece. In the cycle after acceptance, `done` is high with `done_bytes` equal to 0, and `busy` stays low.
- R8: `req_ready` is high exactly when the block is idle. A request presented while `busy` is high is ignored: it produces no piece and no completion.
- R9: After reset, `req_ready` is high and `busy`, `chk_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_offset | input | OFF_W | Start byte offset in flash |
| req_len | input | LEN_W | Total byte count |
| req_write | input | 1 | Direction: 0 read, 1 write |
| busy | output | 1 | A transfer is in progress |
| chk_valid | output | 1 | A piece is offered downstream |
| chk_ready | input | 1 | Downstream acknowledges completion of the piece |
| chk_offset | output | OFF_W | Piece start offset |
| chk_len | output | LEN_W | Piece byte count |
| chk_write | output | 1 | Piece direction: 0 read, 1 write |
| done | output | 1 | One-cycle completion strobe |
| done_bytes | output | LEN_W | Total bytes moved, valid with `done` |

## Verification
A corrupted outstanding-byte count or offset register shows at the very next piece, one cycle after the acknowledge. It appears as a wrong `chk_len` or `chk_offset`, or as a completion strobe that comes too early or never comes. A direction bit latched wrongly shows on the first piece as the wrong `chk_write`. Any unaligned write then shows as a first piece of full page length instead of a short one. A control state that fails to return to idle shows as `req_ready` staying low after `done`. Every error is therefore visible within one piece of where it starts.

// File: rtl/xc_pkg.sv
package xc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_WAIT = 2'd2
  } xc_state_e;
endpackage

// File: rtl/xc_chunk_calc.sv
// Combinational piece-length selector: page-limited for reads,
// boundary-limited for writes.
module xc_chunk_calc #(
  parameter int LEN_W      = 28,
  parameter int CHUNK_LOG2 = 12
) (
  input  logic [CHUNK_LOG2-1:0] off_lo,
  input  logic [LEN_W-1:0]      remain,
  input  logic                  is_write,
  output logic [LEN_W-1:0]      piece_len
);
  localparam logic [LEN_W-1:0] PAGE = LEN_W'(1) << CHUNK_LOG2;

  logic [LEN_W-1:0] room;

  always_comb begin
    // Writes may only run to the next page boundary; reads get a full page.
    if (is_write) room = PAGE - LEN_W'(off_lo);
    else          room = PAGE;
    piece_len = (remain < room) ? remain : room;
  end
endmodule

// File: rtl/xc_seq.sv
// Sequencer: accepts a request, issues one piece at a time, advances
// offset and outstanding count on each acknowledge.
module xc_seq
  import xc_pkg::*;
#(
  parameter int OFF_W      = 32,
  parameter int LEN_W      = 28,
  parameter int CHUNK_LOG2 = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [OFF_W-1:0]      req_offset,
  input  logic [LEN_W-1:0]      req_len,
  input  logic                  req_write,
  output logic                  busy,
  output logic                  chk_valid,
  input  logic                  chk_ready,
  output logic [OFF_W-1:0]      chk_offset,
  output logic [LEN_W-1:0]      chk_len,
  output logic                  chk_write,
  output logic                  done,
  output logic [LEN_W-1:0]      done_bytes,
  output logic [CHUNK_LOG2-1:0] cur_off_lo,
  output logic [LEN_W-1:0]      cur_remain,
  output logic                  cur_write,
  input  logic [LEN_W-1:0]      next_len
);
  localparam logic [LEN_W:0] PAGE_X = (LEN_W+1)'(1) << CHUNK_LOG2;

  xc_state_e        state;
  logic [OFF_W-1:0] cur_off;
  logic [LEN_W-1:0] remain;
  logic [LEN_W-1:0] moved;
  logic             dir;

  assign cur_off_lo = cur_off[CHUNK_LOG2-1:0];
  assign cur_remain = remain;
  assign cur_write  = dir;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      req_ready  <= 1'b1;
      busy       <= 1'b0;
      chk_valid  <= 1'b0;
      chk_offset <= '0;
      chk_len    <= '0;
      chk_write  <= 1'b0;
      done       <= 1'b0;
      done_bytes <= '0;
      cur_off    <= '0;
      remain     <= '0;
      moved      <= '0;
      dir        <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_off   <= req_offset;
            remain    <= req_len;
            dir       <= req_write;
            chk_write <= req_write;
            moved     <= '0;
            if (req_len == '0) begin
              done       <= 1'b1;
              done_bytes <= '0;
            end else begin
              state     <= ST_CALC;
              busy      <= 1'b1;
              req_ready <= 1'b0;
            end
          end
        end
        ST_CALC: begin
          chk_valid  <= 1'b1;
          chk_offset <= cur_off;
          chk_len    <= next_len;
          state      <= ST_WAIT;
        end
        ST_WAIT: begin
          if (chk_ready) begin
            chk_valid <= 1'b0;
            cur_off   <= cur_off + OFF_W'(chk_len);
            remain    <= remain - chk_len;
            moved     <= moved + chk_len;
            if (remain == chk_len) begin
              done       <= 1'b1;
              done_bytes <= moved + chk_len;
              busy       <= 1'b0;
              req_ready  <= 1'b1;
              state      <= ST_IDLE;
            end else begin
              state <= ST_CALC;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1/R3: a piece is never empty and never larger than a page
  a_r1_piece_bounded: assert property (@(posedge clk) disable iff (rst)
    chk_valid |-> (chk_len != '0) && ({1'b0, chk_len} <= PAGE_X));

  // R2: a write piece stays inside its page
  a_r2_no_page_cross: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_write) |->
      ((LEN_W+1)'(chk_offset[CHUNK_LOG2-1:0]) + {1'b0, chk_len} <= PAGE_X));

  // R5: offered piece is held until acknowledged
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && !chk_ready) |=>
      (chk_valid && $stable(chk_offset) && $stable(chk_len) && $stable(chk_write)));

  // R5: acknowledge drops valid for a cycle
  a_r5_gap_after_ack: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_ready) |=> !chk_valid);

  // R6: completion only when nothing is outstanding
  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !chk_valid && req_ready));

  // R8: never ready while busy; pieces only while busy
  a_r8_ready_excl: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready);
  a_r8_piece_in_busy: assert property (@(posedge clk) disable iff (rst)
    chk_valid |-> busy);
endmodule

// File: rtl/xfer_chunker.sv
module xfer_chunker #(
  parameter int OFF_W      = 32,
  parameter int LEN_W      = 28,
  parameter int CHUNK_LOG2 = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [OFF_W-1:0] req_offset,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_write,
  output logic             busy,
  output logic             chk_valid,
  input  logic             chk_ready,
  output logic [OFF_W-1:0] chk_offset,
  output logic [LEN_W-1:0] chk_len,
  output logic             chk_write,
  output logic             done,
  output logic [LEN_W-1:0] done_bytes
);
  logic [CHUNK_LOG2-1:0] off_lo;
  logic [LEN_W-1:0]      remain;
  logic                  dir;
  logic [LEN_W-1:0]      piece_len;

  xc_chunk_calc #(
    .LEN_W(LEN_W), .CHUNK_LOG2(CHUNK_LOG2)
  ) calc_i (
    .off_lo(off_lo), .remain(remain), .is_write(dir), .piece_len(piece_len)
  );

  xc_seq #(
    .OFF_W(OFF_W), .LEN_W(LEN_W), .CHUNK_LOG2(CHUNK_LOG2)
  ) seq_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_offset(req_offset), .req_len(req_len), .req_write(req_write),
    .busy(busy),
    .chk_valid(chk_valid), .chk_ready(chk_ready),
    .chk_offset(chk_offset), .chk_len(chk_len), .chk_write(chk_write),
    .done(done), .done_bytes(done_bytes),
    .cur_off_lo(off_lo), .cur_remain(remain), .cur_write(dir),
    .next_len(piece_len)
  );
endmodule

// File: tb/xfer_chunker_tb_top.sv
`timescale 1ns/1ps
module xfer_chunker_tb_top;
  localparam int OFF_W = 32;
  localparam int LEN_W = 28;
  localparam int PAGE  = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [OFF_W-1:0] req_offset = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_write = 1'b0;
  logic busy, chk_valid, chk_write, done;
  logic chk_ready = 1'b0;
  logic [OFF_W-1:0] chk_offset;
  logic [LEN_W-1:0] chk_len, done_bytes;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  xfer_chunker #(.OFF_W(OFF_W), .LEN_W(LEN_W), .CHUNK_LOG2(12)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_offset(req_offset), .req_len(req_len), .req_write(req_write),
    .busy(busy),
    .chk_valid(chk_valid), .chk_ready(chk_ready),
    .chk_offset(chk_offset), .chk_len(chk_len), .chk_write(chk_write),
    .done(done), .done_bytes(done_bytes)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_len(input longint off, input longint rem, input bit w);
    longint room;
    room = w ? (PAGE - (off % PAGE)) : PAGE;
    return (rem < room) ? rem : room;
  endfunction

  task automatic wait_piece(output bit got);
    got = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (chk_valid) begin got = 1'b1; break; end
    end
  endtask

  // Runs one transfer; checks every piece, hold, gap, completion.
  task automatic run_xfer(input longint off, input longint len, input bit w,
                          input int stall, input bit poke, input string tag);
    longint e_off, e_rem, e_len;
    bit got;
    @(negedge clk);
    check(req_ready == 1'b1, {"R8 ready when idle ", tag}, req_ready, 1);
    req_offset = OFF_W'(off); req_len = LEN_W'(len); req_write = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1 && req_ready == 1'b0, {"R8 busy after accept ", tag}, busy, 1);
    e_off = off; e_rem = len;
    while (e_rem > 0) begin
      e_len = exp_len(e_off, e_rem, w);
      wait_piece(got);
      check(got, {"R5 piece offered ", tag}, got, 1);
      if (!got) return;
      check(chk_offset == OFF_W'(e_off), {"R4 piece offset ", tag}, chk_offset, e_off);
      if (!w)
        check(chk_len == LEN_W'(e_len), {"R1 read piece length ", tag}, chk_len, e_len);
      else if (e_off % PAGE != 0)
        check(chk_len == LEN_W'(e_len), {"R2 unaligned write length ", tag}, chk_len, e_len);
      else
        check(chk_len == LEN_W'(e_len), {"R3 aligned write length ", tag}, chk_len, e_len);
      check(chk_write == w, {"R4 direction bit ", tag}, chk_write, w);
      for (int s = 0; s < stall; s++) begin
        if (poke) begin
          req_offset = 32'hDEAD0000; req_len = 28'd77; req_write = ~w; req_valid = 1'b1;
        end
        @(negedge clk);
        check(chk_valid && chk_offset == OFF_W'(e_off) && chk_len == LEN_W'(e_len),
              {"R5 hold while stalled ", tag}, chk_len, e_len);
        if (poke) check(req_ready == 1'b0, {"R8 not ready while busy ", tag}, req_ready, 0);
      end
      req_valid = 1'b0;
      chk_ready = 1'b1;
      @(negedge clk);
      chk_ready = 1'b0;
      e_off += e_len; e_rem -= e_len;
      if (e_rem == 0) begin
        check(done == 1'b1, {"R6 done strobe ", tag}, done, 1);
        check(done_bytes == LEN_W'(len), {"R6 done byte count ", tag}, done_bytes, len);
        check(!busy && !chk_valid && req_ready, {"R6 idle at done ", tag}, busy, 0);
      end else begin
        check(chk_valid == 1'b0, {"R5 gap after ack ", tag}, chk_valid, 0);
      end
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!chk_valid && !done, {"R8 nothing after completion ", tag}, chk_valid, 0);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(req_ready == 1'b1, "R9 reset req_ready", req_ready, 1);
    check(busy == 1'b0, "R9 reset busy", busy, 0);
    check(chk_valid == 1'b0, "R9 reset chk_valid", chk_valid, 0);
    check(done == 1'b0, "R9 reset done", done, 0);
  endtask

  task automatic t_zero_len();
    @(negedge clk);
    req_offset = 32'h345; req_len = '0; req_write = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(done == 1'b1, "R7 zero length done", done, 1);
    check(done_bytes == '0, "R7 zero length count", done_bytes, 0);
    check(busy == 1'b0, "R7 zero length not busy", busy, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!chk_valid && !done, "R7 zero length issues no piece", chk_valid, 0);
    end
  endtask

  initial begin
    #500000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    run_xfer(64'h1000, 10000, 1'b0, 0, 1'b0, "read aligned");
    run_xfer(64'h0123, 9000,  1'b0, 2, 1'b0, "read unaligned");
    run_xfer(64'h0F00, 9000,  1'b1, 1, 1'b0, "write unaligned");
    run_xfer(64'h2000, 4096,  1'b1, 0, 1'b0, "write one page");
    run_xfer(64'h0010, 20,    1'b1, 0, 1'b0, "write inside page");
    run_xfer(64'h0F00, 256,   1'b1, 0, 1'b0, "write to boundary");
    run_xfer(64'h5FFF, 4098,  1'b1, 0, 1'b0, "write one byte before boundary");
    t_zero_len();
    run_xfer(64'h7800, 6000,  1'b0, 3, 1'b1, "read with busy poke");
    run_xfer(64'h7800, 6000,  1'b1, 3, 1'b1, "write with busy poke");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule